// File: doc/BRIEF.md
# Pulse Interval and Duty Cycle Capture Cell

This block times one digital input line. The line passes through a synchroniser, and an edge detector then feeds a selectable event qualifier. A saturating interval timer restarts on every event, and its value at that moment is latched into capture storage. Each captured value is therefore the interval in clock cycles since the previous event. Software reads period or high/low times directly from the captures, with no subtraction.

The cell has two capture modes. In single mode every event overwrites the first capture register. In double mode successive events alternate between the first and second register, and the valid strobe marks the completed pair. A programmable timeout watches for an expected edge that does not arrive. When the timer reaches the timeout with no event, a sticky missing-pulse flag is raised. If reconstruction is enabled, a substitute event is also produced. It is captured and it restarts the timer exactly like a real edge.

Top module: `dcm_cell`

## Requirements
- R1: After synchronous reset, `cap_a` and `cap_b` are zero and `cap_valid` and `miss_flag` are low.
- R2: `edge_sel` encodes the qualifying edges as 2'b01 rising only, 2'b10 falling only, 2'b11 both, 2'b00 none. Edges of a type that is not selected produce no capture and no `cap_valid`.
- R3: `sig_in` passes through two flops. A qualifying change driven before clock edge k is captured, and `cap_valid` pulses for one cycle, on edge k+2.
- R4: The captured value equals the number of clock cycles between two successive events, because the timer restarts on each event.
- R5: In single mode (`dbl_mode`=0), every event writes `cap_a` and pulses `cap_valid`, and `cap_b` does not change.
- R6: In double mode, events alternate. The first event of a pair writes `cap_a` with no strobe. The second writes `cap_b` and pulses `cap_valid` while `cap_a` holds. Reset or single mode returns the cell to the first slot.
- R7: The timer stops at its all-ones value instead of wrapping, so an over-long interval captures all ones.
- R8: With `timeout_val` nonzero, when the timer equals `timeout_val` in a cycle without an event, `miss_flag` sets on the next edge. A `timeout_val` of zero disables detection.
- R9: With `recon_en`=0, a timeout causes no capture and no `cap_valid`.
- R10: With `recon_en`=1, a timeout produces a substitute event. It captures the value `timeout_val`, pulses `cap_valid` in single mode and restarts the timer, so a silent input repeats it every `timeout_val` cycles.
- R11: A real event in the cycle the timer equals `timeout_val` takes priority: no missing pulse is flagged.
- R12: `miss_flag` is sticky until `miss_clr` is asserted in a cycle without a new timeout.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sig_in | input | 1 | Measured signal, asynchronous to clk |
| edge_sel | input | 2 | Qualifying edge selection |
| dbl_mode | input | 1 | 1 = double capture, 0 = single capture |
| recon_en | input | 1 | Enable substitute event on timeout |
| timeout_val | input | CNT_W | Predicted maximum interval, 0 disables |
| miss_clr | input | 1 | Clears the missing-pulse flag |
| cap_a | output | CNT_W | First capture register |
| cap_b | output | CNT_W | Second capture register (double mode) |
| cap_valid | output | 1 | One-cycle strobe when a capture result is complete |
| miss_flag | output | 1 | Sticky missing-pulse flag |

## Verification
The cell is driven with asymmetric square waves whose high and low times differ. This separates rising-only, falling-only and both-edge qualification, and it separates which phase lands in which register in double mode. A silent input after one edge tests the timeout twice. Without reconstruction, the flag must rise on exactly the predicted cycle with no capture. With reconstruction, substitute captures must repeat at the timeout spacing. A periodic input whose period equals the timeout checks that a real edge wins the tie. An interval longer than the counter range checks saturation.

// File: rtl/dcm_pkg.sv
package dcm_pkg;

    typedef enum logic [1:0] {
        SEL_NONE = 2'b00,
        SEL_RISE = 2'b01,
        SEL_FALL = 2'b10,
        SEL_BOTH = 2'b11
    } edge_sel_e;

    typedef struct packed {
        logic rise;
        logic fall;
    } edge_evt_t;

    typedef enum logic {
        SLOT_FIRST  = 1'b0,
        SLOT_SECOND = 1'b1
    } cap_slot_e;

    function automatic logic edge_qualifies(input edge_sel_e sel, input edge_evt_t evt);
        logic q;
        case (sel)
            SEL_RISE: q = evt.rise;
            SEL_FALL: q = evt.fall;
            SEL_BOTH: q = evt.rise | evt.fall;
            default:  q = 1'b0;
        endcase
        return q;
    endfunction

endpackage

// File: rtl/dcm_edge_sync.sv
module dcm_edge_sync
    import dcm_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      sig_in,
    output edge_evt_t edges
);
    localparam int LAST = SYNC_STAGES - 1;

    logic [SYNC_STAGES-1:0] chain;
    logic                   prev_lvl;

    always_ff @(posedge clk) begin
        if (rst) begin
            chain    <= '0;
            prev_lvl <= 1'b0;
        end else begin
            chain[0] <= sig_in;
            prev_lvl <= chain[LAST];
        end
    end

    generate
        for (genvar g = 1; g < SYNC_STAGES; g++) begin : g_stage
            always_ff @(posedge clk) begin
                if (rst) chain[g] <= 1'b0;
                else     chain[g] <= chain[g-1];
            end
        end
    endgenerate

    always_comb begin
        edges.rise = chain[LAST] & ~prev_lvl;
        edges.fall = ~chain[LAST] & prev_lvl;
    end

endmodule

// File: rtl/dcm_interval_timer.sv
module dcm_interval_timer #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             restart,
    output logic [CNT_W-1:0] count
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
    localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

    always_ff @(posedge clk) begin
        if (rst)                 count <= '0;
        else if (restart)        count <= CNT_ONE;
        else if (count != CNT_MAX) count <= count + CNT_ONE;
    end

endmodule

// File: rtl/dcm_miss_guard.sv
module dcm_miss_guard #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [CNT_W-1:0] count,
    input  logic [CNT_W-1:0] timeout_val,
    input  logic             real_evt,
    input  logic             recon_en,
    input  logic             miss_clr,
    output logic             synth_evt,
    output logic             miss_flag
);
    logic armed;
    logic hit;

    always_comb begin
        armed     = (timeout_val != '0);
        hit       = armed && (count == timeout_val) && !real_evt;
        synth_evt = hit && recon_en;
    end

    always_ff @(posedge clk) begin
        if (rst)           miss_flag <= 1'b0;
        else if (hit)      miss_flag <= 1'b1;
        else if (miss_clr) miss_flag <= 1'b0;
    end

endmodule

// File: rtl/dcm_capture_bank.sv
module dcm_capture_bank
    import dcm_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             evt,
    input  logic             dbl_mode,
    input  logic [CNT_W-1:0] count,
    output logic [CNT_W-1:0] cap_a,
    output logic [CNT_W-1:0] cap_b,
    output logic             cap_valid
);
    cap_slot_e slot;

    always_ff @(posedge clk) begin
        if (rst) begin
            cap_a     <= '0;
            cap_b     <= '0;
            cap_valid <= 1'b0;
            slot      <= SLOT_FIRST;
        end else begin
            cap_valid <= 1'b0;
            if (!dbl_mode) slot <= SLOT_FIRST;
            if (evt) begin
                if (!dbl_mode) begin
                    cap_a     <= count;
                    cap_valid <= 1'b1;
                end else if (slot == SLOT_FIRST) begin
                    cap_a <= count;
                    slot  <= SLOT_SECOND;
                end else begin
                    cap_b     <= count;
                    cap_valid <= 1'b1;
                    slot      <= SLOT_FIRST;
                end
            end
        end
    end

endmodule

// File: rtl/dcm_cell.sv
module dcm_cell
    import dcm_pkg::*;
#(
    parameter int CNT_W       = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             sig_in,
    input  logic [1:0]       edge_sel,
    input  logic             dbl_mode,
    input  logic             recon_en,
    input  logic [CNT_W-1:0] timeout_val,
    input  logic             miss_clr,
    output logic [CNT_W-1:0] cap_a,
    output logic [CNT_W-1:0] cap_b,
    output logic             cap_valid,
    output logic             miss_flag
);
    edge_evt_t        edges;
    logic             real_evt;
    logic             synth_evt;
    logic             any_evt;
    logic [CNT_W-1:0] tmr_cnt;

    dcm_edge_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst   (rst),
        .sig_in(sig_in),
        .edges (edges)
    );

    always_comb begin
        real_evt = edge_qualifies(edge_sel_e'(edge_sel), edges);
        any_evt  = real_evt | synth_evt;
    end

    dcm_interval_timer #(.CNT_W(CNT_W)) u_tmr (
        .clk    (clk),
        .rst    (rst),
        .restart(any_evt),
        .count  (tmr_cnt)
    );

    dcm_miss_guard #(.CNT_W(CNT_W)) u_miss (
        .clk        (clk),
        .rst        (rst),
        .count      (tmr_cnt),
        .timeout_val(timeout_val),
        .real_evt   (real_evt),
        .recon_en   (recon_en),
        .miss_clr   (miss_clr),
        .synth_evt  (synth_evt),
        .miss_flag  (miss_flag)
    );

    dcm_capture_bank #(.CNT_W(CNT_W)) u_cap (
        .clk      (clk),
        .rst      (rst),
        .evt      (any_evt),
        .dbl_mode (dbl_mode),
        .count    (tmr_cnt),
        .cap_a    (cap_a),
        .cap_b    (cap_b),
        .cap_valid(cap_valid)
    );

endmodule

// File: rtl/dcm_cell_checker.sv
module dcm_cell_checker #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst,
    input logic [1:0]       edge_sel,
    input logic             dbl_mode,
    input logic             recon_en,
    input logic [CNT_W-1:0] timeout_val,
    input logic             miss_clr,
    input logic [CNT_W-1:0] cap_a,
    input logic [CNT_W-1:0] cap_b,
    input logic             cap_valid,
    input logic             miss_flag,
    input logic [CNT_W-1:0] cnt,
    input logic             evt,
    input logic             real_evt,
    input logic             synth
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    p_none_ignored_r2: assert property (@(posedge clk) disable iff (rst)
        (edge_sel == 2'b00 && !recon_en) |=> !cap_valid);

    p_single_b_hold_r5: assert property (@(posedge clk) disable iff (rst)
        !dbl_mode |=> $stable(cap_b));

    p_double_a_hold_r6: assert property (@(posedge clk) disable iff (rst)
        ($past(dbl_mode) && cap_valid) |-> $stable(cap_a));

    p_saturate_r7: assert property (@(posedge clk) disable iff (rst)
        (cnt == CNT_MAX && !evt) |=> (cnt == CNT_MAX));

    p_miss_cause_r8: assert property (@(posedge clk) disable iff (rst)
        $rose(miss_flag) |-> $past(cnt == timeout_val && timeout_val != '0));

    p_synth_value_r10: assert property (@(posedge clk) disable iff (rst)
        (synth && !dbl_mode) |=> (cap_valid && cap_a == $past(timeout_val)));

    p_real_wins_r11: assert property (@(posedge clk) disable iff (rst)
        real_evt |=> !$rose(miss_flag));

    p_sticky_r12: assert property (@(posedge clk) disable iff (rst)
        (miss_flag && !miss_clr) |=> miss_flag);

endmodule

bind dcm_cell dcm_cell_checker #(.CNT_W(CNT_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .edge_sel   (edge_sel),
    .dbl_mode   (dbl_mode),
    .recon_en   (recon_en),
    .timeout_val(timeout_val),
    .miss_clr   (miss_clr),
    .cap_a      (cap_a),
    .cap_b      (cap_b),
    .cap_valid  (cap_valid),
    .miss_flag  (miss_flag),
    .cnt        (tmr_cnt),
    .evt        (any_evt),
    .real_evt   (real_evt),
    .synth      (synth_evt)
);

// File: tb/sim_dcm_cell.sv
`timescale 1ns/1ps
module sim_dcm_cell;
    localparam int CW = 12;
    localparam logic [CW-1:0] MAXV = {CW{1'b1}};

    logic          clk = 1'b0;
    logic          rst;
    logic          sig_in;
    logic [1:0]    edge_sel;
    logic          dbl_mode;
    logic          recon_en;
    logic [CW-1:0] timeout_val;
    logic          miss_clr;
    logic [CW-1:0] cap_a, cap_b;
    logic          cap_valid, miss_flag;

    int checks = 0;
    int errors = 0;
    int nval;
    logic [CW-1:0] sa, sb;
    logic          sv;

    always #2 clk = ~clk;

    dcm_cell #(.CNT_W(CW)) u0 (
        .clk(clk), .rst(rst), .sig_in(sig_in), .edge_sel(edge_sel),
        .dbl_mode(dbl_mode), .recon_en(recon_en), .timeout_val(timeout_val),
        .miss_clr(miss_clr), .cap_a(cap_a), .cap_b(cap_b),
        .cap_valid(cap_valid), .miss_flag(miss_flag)
    );

    task automatic check(input logic ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic do_reset(input logic [1:0] es, input logic dbl, input logic rec,
                            input int tmo);
        @(negedge clk);
        rst = 1'b1; sig_in = 1'b0; miss_clr = 1'b0;
        edge_sel = es; dbl_mode = dbl; recon_en = rec; timeout_val = CW'(tmo);
        repeat (3) @(negedge clk);
        rst = 1'b0;
    endtask

    // Set level now (at a falling clock edge), then wait n cycles; snapshot at the third.
    task automatic drive(input logic v, input int n);
        sig_in = v;
        nval = 0;
        for (int i = 1; i <= n; i++) begin
            @(negedge clk);
            if (cap_valid) nval++;
            if (i == 3) begin sa = cap_a; sb = cap_b; sv = cap_valid; end
        end
    endtask

    task automatic t_reset_state;
        do_reset(2'b01, 1'b0, 1'b0, 0);
        check(cap_a == 0 && cap_b == 0, "R1 caps", int'(cap_a) + int'(cap_b), 0);
        check(!cap_valid && !miss_flag, "R1 flags", int'(cap_valid) + int'(miss_flag), 0);
    endtask

    task automatic t_rise_single;
        do_reset(2'b01, 1'b0, 1'b0, 0);
        drive(1, 6);
        drive(0, 4);
        check(sv == 0, "R2 falling ignored under rising select", sv, 0);
        drive(1, 3);
        check(sv == 1, "R3 strobe two edges after sync", sv, 1);
        check(sa == 10, "R4 rising period", sa, 10);
        check(sb == 0, "R5 cap_b untouched in single mode", sb, 0);
    endtask

    task automatic t_fall_single;
        do_reset(2'b10, 1'b0, 1'b0, 0);
        drive(1, 4);
        check(sv == 0, "R2 rising ignored under falling select", sv, 0);
        drive(0, 7);
        drive(1, 4);
        check(sv == 0, "R2 rising ignored under falling select", sv, 0);
        drive(0, 3);
        check(sv == 1 && sa == 11, "R4 falling period", sa, 11);
    endtask

    task automatic t_both_single;
        do_reset(2'b11, 1'b0, 1'b0, 0);
        drive(1, 7);
        drive(0, 5);
        check(sv == 1 && sa == 7, "R4 high time on both edges", sa, 7);
        drive(1, 3);
        check(sv == 1 && sa == 5, "R4 low time on both edges", sa, 5);
    endtask

    task automatic t_none;
        do_reset(2'b00, 1'b0, 1'b0, 0);
        drive(1, 5);
        check(nval == 0, "R2 no capture with none selected", nval, 0);
        drive(0, 5);
        check(nval == 0 && cap_a == 0, "R2 no capture with none selected", cap_a, 0);
    endtask

    task automatic t_double;
        do_reset(2'b11, 1'b1, 1'b0, 0);
        drive(1, 5);
        check(sv == 0, "R6 first slot no strobe", sv, 0);
        drive(0, 3);
        check(sv == 1 && sb == 5, "R6 second slot high time", sb, 5);
        drive(1, 6);
        check(sv == 0 && sa == 3, "R6 first slot low time", sa, 3);
        drive(0, 4);
        check(sv == 1 && sb == 6, "R6 second slot high time", sb, 6);
        check(sa == 3, "R6 cap_a holds on pair completion", sa, 3);
    endtask

    task automatic t_saturate;
        do_reset(2'b01, 1'b0, 1'b0, 0);
        drive(1, 3);
        drive(0, 4200);
        drive(1, 3);
        check(sa == MAXV, "R7 saturated capture", sa, int'(MAXV));
    endtask

    task automatic t_miss_no_recon;
        int cnt_v;
        do_reset(2'b01, 1'b0, 1'b0, 20);
        drive(1, 3);
        cnt_v = 0;
        for (int i = 0; i < 19; i++) begin @(negedge clk); if (cap_valid) cnt_v++; end
        check(miss_flag == 0, "R8 flag not before timeout", miss_flag, 0);
        @(negedge clk);
        check(miss_flag == 1, "R8 flag on timeout", miss_flag, 1);
        for (int i = 0; i < 10; i++) begin @(negedge clk); if (cap_valid) cnt_v++; end
        check(cnt_v == 0, "R9 no capture without reconstruction", cnt_v, 0);
        check(miss_flag == 1, "R12 flag sticky", miss_flag, 1);
        miss_clr = 1'b1;
        @(negedge clk);
        miss_clr = 1'b0;
        check(miss_flag == 0, "R12 clear", miss_flag, 0);
    endtask

    task automatic t_timeout_zero;
        do_reset(2'b01, 1'b0, 1'b1, 0);
        drive(1, 300);
        check(miss_flag == 0 && nval == 1, "R8 zero timeout disables", nval, 1);
    endtask

    task automatic t_recon;
        do_reset(2'b01, 1'b0, 1'b1, 12);
        drive(1, 3);
        nval = 0;
        for (int i = 0; i < 36; i++) begin @(negedge clk); if (cap_valid) nval++; end
        check(nval == 3, "R10 substitute events every timeout", nval, 3);
        check(cap_a == 12, "R10 substitute capture value", cap_a, 12);
        check(miss_flag == 1, "R10 flag set on substitute", miss_flag, 1);
    endtask

    task automatic t_real_wins;
        do_reset(2'b01, 1'b0, 1'b1, 10);
        drive(1, 5);
        drive(0, 5);
        drive(1, 5);
        drive(0, 5);
        drive(1, 3);
        check(sa == 10, "R11 period equal to timeout", sa, 10);
        check(miss_flag == 0, "R11 real edge wins tie", miss_flag, 0);
    endtask

    initial begin
        rst = 1'b1; sig_in = 1'b0; edge_sel = 2'b01; dbl_mode = 1'b0;
        recon_en = 1'b0; timeout_val = '0; miss_clr = 1'b0;
        t_reset_state();
        t_rise_single();
        t_fall_single();
        t_both_single();
        t_none();
        t_double();
        t_saturate();
        t_miss_no_recon();
        t_timeout_zero();
        t_recon();
        t_real_wins();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule